// File: doc/BRIEF.md
# Low-Level Noise Squelch Gate

This block sits in a 16-bit streaming sample path, ahead of stages that boost selected frequency bands. It watches the size of each incoming sample. When a long, unbroken run of samples stays below a programmable level, the block replaces further samples with zero. Boosting filters downstream then see silence instead of amplified idle-channel hiss. The gate applies the same way whatever processing mode the downstream path is in, so it has no mode input.

The level is an 8-bit value held in an internal register. It is loaded through a write strobe and comes out of reset at 1Fh. The hold time is a parameter counted in accepted samples. The default of 200 matches 25 ms at an 8 kHz sample rate.

A single loud sample opens the gate again at once. That sample passes through unchanged, and the quiet run starts over from zero. Results leave through a registered output with one cycle of latency.

Top module: `squelch_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0, the level register holds 1Fh and the quiet-run count is zero.
- R2: out_valid equals the in_valid of the previous clock cycle.
- R3: The magnitude of a sample is its two's-complement absolute value. The value 8000h saturates to 7FFFh.
- R4: A valid sample is quiet exactly when its magnitude is strictly less than the level, with the 8-bit level zero-extended to 16 bits. A magnitude equal to the level is loud.
- R5: In an unbroken run of quiet valid samples, the first HOLD_COUNT samples pass unchanged. Every later sample of the run is output as 0000h.
- R6: A loud valid sample is output unchanged and ends the run. The next quiet sample counts as the first of a new run.
- R7: Cycles with in_valid low neither advance nor break a quiet run.
- R8: thr_wr loads thr_data into the level register at the clock edge. A sample accepted in the same cycle is judged against the old level. A write does not clear the run count.
- R9: With a level of 00h no sample is quiet, so the gate never engages and no run builds up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| thr_wr | input | 1 | Level register write strobe |
| thr_data | input | 8 | New level value |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Gated sample, meaningful when out_valid is 1 |

## Verification
Every gated sample appears one clock edge after it is accepted. The bench drives inputs on a falling edge and checks out_valid and out_sample on the next falling edge, once the single output register has loaded. A level write takes effect at the same edge that accepts the sample presented alongside it. The bench's model therefore judges that sample against the old level and switches to the new level afterwards. Stored run state cannot be read at the ports. The bench exposes it through the next sample's output, for example a sample of 0001h sent after the level is raised.

// File: rtl/squelch_pkg.sv
// squelch_pkg: shared defaults for the squelch gate.
// Assumes: consumers take widths from here unless overridden by parameter.
package squelch_pkg;
    localparam int SQ_SAMPLE_W     = 16;
    localparam int SQ_THR_W        = 8;
    localparam int SQ_HOLD_DEFAULT = 200;
    localparam logic [7:0] SQ_THR_RESET = 8'h1F;
endpackage

// File: rtl/squelch_level_reg.sv
// squelch_level_reg: holds the programmable squelch level.
// Assumes: a write lands at the clock edge; reset gives RESET_VAL.
module squelch_level_reg #(
    parameter int                THR_W     = 8,
    parameter logic [THR_W-1:0]  RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [THR_W-1:0] wr_data,
    output logic [THR_W-1:0] level
);
    // Load a new level on write, default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= RESET_VAL;
        end else if (wr_en) begin
            level <= wr_data;
        end
    end
endmodule

// File: rtl/squelch_magnitude.sv
// squelch_magnitude: saturating absolute value and comparison with the level.
// Assumes: sample is two's complement; level is unsigned and narrower.
module squelch_magnitude #(
    parameter int SAMPLE_W = 16,
    parameter int THR_W    = 8
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [THR_W-1:0]    level,
    output logic [SAMPLE_W-1:0] magnitude,
    output logic                quiet
);
    localparam int PAD_W = SAMPLE_W - THR_W;
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic [SAMPLE_W-1:0] level_wide;

    // Saturating absolute value of the sample.
    always_comb begin
        if (sample == MOST_NEG) begin
            magnitude = MOST_POS;
        end else if (sample[SAMPLE_W-1]) begin
            magnitude = ~sample + {{(SAMPLE_W-1){1'b0}}, 1'b1};
        end else begin
            magnitude = sample;
        end
    end

    // Zero-extend the level and test strictly below.
    always_comb begin
        level_wide = {{PAD_W{1'b0}}, level};
        quiet      = (magnitude < level_wide);
    end
endmodule

// File: rtl/squelch_hold_counter.sv
// squelch_hold_counter: counts consecutive quiet samples and decides muting.
// Assumes: only valid samples affect the count; count saturates at HOLD_COUNT.
module squelch_hold_counter #(
    parameter int HOLD_COUNT = 200,
    parameter int CNT_W      = $clog2(HOLD_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic             quiet,
    output logic [CNT_W-1:0] run_count,
    output logic             mute
);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_COUNT);

    logic run_full;

    // Decide muting from the count held before this sample.
    always_comb begin
        run_full = (run_count == HOLD_LIM);
        mute     = sample_valid && quiet && run_full;
    end

    // Advance on quiet, restart on loud, hold when no sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_count <= '0;
        end else if (sample_valid) begin
            if (!quiet) begin
                run_count <= '0;
            end else if (!run_full) begin
                run_count <= run_count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/squelch_gate.sv
// squelch_gate: zeroes samples after a long run below a programmable level.
// Assumes: one sample per in_valid cycle; output registered with one cycle latency.
module squelch_gate #(
    parameter int               SAMPLE_W   = squelch_pkg::SQ_SAMPLE_W,
    parameter int               THR_W      = squelch_pkg::SQ_THR_W,
    parameter int               HOLD_COUNT = squelch_pkg::SQ_HOLD_DEFAULT,
    parameter logic [THR_W-1:0] THR_RESET  = THR_W'(squelch_pkg::SQ_THR_RESET)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                thr_wr,
    input  logic [THR_W-1:0]    thr_data,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);
    localparam int CNT_W = $clog2(HOLD_COUNT + 1);

    logic [THR_W-1:0]    level_q;
    logic [SAMPLE_W-1:0] magnitude;
    logic                quiet;
    logic [CNT_W-1:0]    run_count;
    logic                mute;

    squelch_level_reg #(.THR_W(THR_W), .RESET_VAL(THR_RESET)) level_i (
        .clk(clk), .rst_n(rst_n), .wr_en(thr_wr), .wr_data(thr_data), .level(level_q)
    );

    squelch_magnitude #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) mag_i (
        .sample(in_sample), .level(level_q), .magnitude(magnitude), .quiet(quiet)
    );

    squelch_hold_counter #(.HOLD_COUNT(HOLD_COUNT), .CNT_W(CNT_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .sample_valid(in_valid), .quiet(quiet),
        .run_count(run_count), .mute(mute)
    );

    // Register the gated sample and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= mute ? '0 : in_sample;
            end
        end
    end
endmodule

// File: rtl/squelch_gate_checker.sv
// squelch_gate_checker: temporal properties of the squelch gate, bound to its top.
// Assumes: reset is synchronous and active low.
module squelch_gate_checker #(
    parameter int               SAMPLE_W   = 16,
    parameter int               THR_W      = 8,
    parameter int               HOLD_COUNT = 200,
    parameter int               CNT_W      = 8,
    parameter logic [THR_W-1:0] THR_RESET  = '1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic                thr_wr,
    input logic [THR_W-1:0]    thr_data,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic [THR_W-1:0]    level_q,
    input logic [SAMPLE_W-1:0] magnitude,
    input logic                quiet,
    input logic [CNT_W-1:0]    run_count,
    input logic                mute
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    assert_reset_level_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (level_q == THR_RESET && run_count == '0 && !out_valid));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_sat_abs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sample == MOST_NEG) |-> (magnitude == MOST_POS));

    assert_mute_only_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> (quiet && in_valid));

    assert_muted_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> (out_sample == '0));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_count <= CNT_W'(HOLD_COUNT));

    assert_loud_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !quiet) |=> (out_sample == $past(in_sample) && run_count == '0));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(run_count));

    assert_level_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (level_q == $past(thr_data)));

    assert_zero_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == '0) |-> !quiet);
endmodule

bind squelch_gate squelch_gate_checker #(
    .SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .HOLD_COUNT(HOLD_COUNT),
    .CNT_W(CNT_W), .THR_RESET(THR_RESET)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .thr_wr(thr_wr), .thr_data(thr_data), .out_valid(out_valid),
    .out_sample(out_sample), .level_q(level_q), .magnitude(magnitude),
    .quiet(quiet), .run_count(run_count), .mute(mute)
);

// File: tb/squelch_gate_tb_top.sv
// squelch_gate_tb_top: self-checking bench with a reduced hold count.
module squelch_gate_tb_top;
    localparam int HOLD = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        thr_wr = 1'b0;
    logic [7:0]  thr_data = '0;
    logic        out_valid;
    logic [15:0] out_sample;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int model_count = 0;
    int model_thr = 31;

    always #2 clk = ~clk;

    squelch_gate #(.HOLD_COUNT(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .thr_wr(thr_wr), .thr_data(thr_data),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int abs_sat(input logic [15:0] s);
        int v;
        v = $signed(s);
        if (v < 0) v = -v;
        if (v > 32767) v = 32767;
        return v;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, check the registered result at the next.
    task automatic step(input logic v, input logic [15:0] s, input logic w,
                        input logic [7:0] d, input string tag);
        logic [15:0] exp;
        exp = s;
        in_valid = v; in_sample = s; thr_wr = w; thr_data = d;
        if (v) begin
            if (abs_sat(s) < model_thr) begin
                if (model_count >= HOLD) exp = '0;
                if (model_count < HOLD) model_count++;
            end else begin
                model_count = 0;
            end
        end
        if (w) model_thr = int'(d);
        @(negedge clk);
        in_valid = 1'b0; thr_wr = 1'b0;
        check({tag, " valid"}, {15'd0, out_valid}, {15'd0, v});
        if (v) check({tag, " data"}, out_sample, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset out_valid", {15'd0, out_valid}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {15'd0, out_valid}, 16'd0);

        // R1 R4: default level 1Fh, 1Eh quiet, run reaches gate
        for (int i = 0; i < HOLD + 3; i++) step(1'b1, 16'h001E, 1'b0, 8'h00, "R1,R4,R5 run");
        // R4 R6: magnitude equal to level is loud and passes, reopening gate
        step(1'b1, 16'h001F, 1'b0, 8'h00, "R4,R6 equal level");
        step(1'b1, 16'hFFE1, 1'b0, 8'h00, "R4,R6 negative equal");
        step(1'b1, 16'h0003, 1'b0, 8'h00, "R6 new run first");

        // R7: gaps inside a run
        for (int i = 0; i < HOLD - 2; i++) step(1'b1, 16'hFFF0, 1'b0, 8'h00, "R7 run");
        for (int i = 0; i < 5; i++) step(1'b0, 16'h7777, 1'b0, 8'h00, "R7 gap");
        step(1'b1, 16'h0002, 1'b0, 8'h00, "R7 last pass");
        step(1'b1, 16'h0002, 1'b0, 8'h00, "R7 gated");
        step(1'b0, 16'h0000, 1'b0, 8'h00, "R2 idle");
        step(1'b1, 16'h0005, 1'b0, 8'h00, "R7 still gated");

        // R8: sample in write cycle judged on old level; write keeps run count
        step(1'b1, 16'h0100, 1'b0, 8'h00, "R6 loud reset");
        step(1'b1, 16'h0010, 1'b1, 8'h05, "R8 old level");
        step(1'b1, 16'h0010, 1'b0, 8'h00, "R8 new level loud");
        for (int i = 0; i < HOLD; i++) step(1'b1, 16'h0004, 1'b0, 8'h00, "R8 run");
        step(1'b0, 16'h0000, 1'b1, 8'h40, "R8 write idle");
        step(1'b1, 16'h0030, 1'b0, 8'h00, "R8 count kept");

        // R9: level zero never engages
        step(1'b0, 16'h0000, 1'b1, 8'h00, "R9 write zero");
        for (int i = 0; i < HOLD + 4; i++) step(1'b1, 16'h0000, 1'b0, 8'h00, "R9 zeros");
        step(1'b0, 16'h0000, 1'b1, 8'h1F, "R9 restore");
        step(1'b1, 16'h0001, 1'b0, 8'h00, "R9 no run built");

        // R3 R4 R5: full sweep of all sample values in ascending signed order
        for (int i = 0; i < 65536; i++)
            step(1'b1, 16'(i) + 16'h8000, 1'b0, 8'h00, "R3,R4,R5 sweep");
        // R3: most negative value is loud and passes
        for (int i = 0; i < HOLD + 2; i++) step(1'b1, 16'h0000, 1'b0, 8'h00, "R5 refill");
        step(1'b1, 16'h8000, 1'b0, 8'h00, "R3 most negative");
        step(1'b1, 16'h0000, 1'b0, 8'h00, "R6 after most negative");

        finish_run();
    end
endmodule